// File: doc/BRIEF.md
# Prescaled Match/Interval Timer Channel

A single 16-bit timer channel programmed through a plain read/write register port. The channel takes its count steps from the system clock or from an external clock pin. The external clock is synchronised into the system clock domain, and either its rising or its falling edge can be chosen. An optional power-of-two prescaler sits between the selected clock and the counter. The counter runs up or down. In free-run mode it wraps at the end of the 16-bit range. In interval mode it wraps at a programmable limit.

Three match registers are compared against the count. Hits, and the wrap event, latch into write-one-to-clear status bits. A plain enable mask combines these bits into a single interrupt line. A waveform output toggles on hits of the second match register and falls back to its idle level on every wrap. Its polarity is selectable, and it can be switched off.

A stop control and a reload command are kept separate. Software can restart the count from its mode-dependent start value without changing whether the channel is running.

Top module: `tmr_channel`

## Requirements
- R1: After reset the control register reads 0x0041 (stopped, internal clock, waveform off). The count, the interval, the enable mask and the status all read 0. The interrupt and waveform outputs are low.
- R2: Register map at `addr`: 0 control, 1 count (read gives the count, any write reloads it), 2 interval, 3/4/5 match 0/1/2, 6 interrupt enable, 7 interrupt status. Control bits: 0 halt, 1 external source, 2 external falling edge, 3 interval mode, 4 count down, 5 match enable, 6 waveform off, 7 waveform polarity, 8 prescaler enable, 12:9 prescaler exponent N.
- R3: With halt clear, internal source and no prescaler, the count changes by one on every system clock edge. It can be read at any time.
- R4: Setting halt freezes the count. Clearing halt resumes from the frozen value without a reload.
- R5: A reload loads 0 when counting up, 0xFFFF when counting down in free-run mode, and the interval value when counting down in interval mode. It leaves the halt bit and the running state untouched.
- R6: In interval mode an up count goes from the interval value to 0, and a down count goes from 0 to the interval value. Each such wrap sets status bit 3.
- R7: In free-run mode the wrap from 0xFFFF to 0 (up) or from 0 to 0xFFFF (down) sets status bit 3.
- R8: With match enable set, a count step landing on match register k sets status bit k (k = 0..2). With match enable clear, no match bit is set.
- R9: Writing status clears each bit written as 1 and leaves the others. An event arriving in the same cycle as the clear wins. `irq` is high exactly when some status bit and its enable bit (same position) are both set.
- R10: With the prescaler enabled, the counter steps once per 2^(N+1) selected clock edges. The prescaler restarts its phase on a reload.
- R11: With the external source selected, the counter steps once per rising edge of `ext_clk`, or once per falling edge when the falling-edge bit is set. The external clock must run below half the system clock rate.
- R12: The waveform state toggles each time a step lands on match register 1 and returns to 0 on every wrap or reload. `wave_out` is the state XOR polarity, or the polarity alone when the waveform is off.
- R13: With count down set, the counter decrements by one per step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External count clock, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Masked OR of the status bits |
| wave_out | output | 1 | Waveform output |

## Verification
The bench aims at the three reload values. A design that ignores the mode in its reload shows 0 or 0xFFFF where the interval value is due. It also checks that a reload during a run keeps the counter stepping; a reload that stopped the channel would leave the count at 0. Wraps are driven in both directions and both modes. A design that tests the wrong end value either never sets status bit 3 or wraps one step early. Prescaler ratios, the choice of external edge, partial status clears and waveform polarity are each checked against step counts worked out by hand. An off-by-one ratio or the wrong edge shows up as a wrong count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IVL    = 3'd2;
  localparam logic [ADDR_W-1:0] A_MATCH0 = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN    = 3'd6;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd7;

  // first field is the most significant: halt lands on bit 0 (R2)
  typedef struct packed {
    logic [3:0] pre_n;
    logic       pre_en;
    logic       wave_pol;
    logic       wave_off;
    logic       match_en;
    logic       count_down;
    logic       interval_mode;
    logic       ext_fall;
    logic       src_ext;
    logic       halt;
  } ctrl_t;

  localparam int CTRL_BITS = $bits(ctrl_t);

  localparam ctrl_t CTRL_RESET = '{pre_n: 4'd0, pre_en: 1'b0, wave_pol: 1'b0,
                                   wave_off: 1'b1, match_en: 1'b0,
                                   count_down: 1'b0, interval_mode: 1'b0,
                                   ext_fall: 1'b0, src_ext: 1'b0, halt: 1'b1};
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PRE_W   = 16,
  parameter int PRE_N_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_clk,
  input  logic               src_ext,
  input  logic               ext_fall,
  input  logic               pre_en,
  input  logic [PRE_N_W-1:0] pre_n,
  input  logic               run,
  input  logic               clear_pre,
  output logic               tick
);
  localparam int SYNC_STAGES = 3;

  // terminal value of the prescaler for a ratio of 2^(n+1)
  function automatic logic [PRE_W-1:0] pre_limit(input logic [PRE_N_W-1:0] n);
    return (PRE_W'(1) << (int'(n) + 1)) - PRE_W'(1);
  endfunction

  logic [SYNC_STAGES-1:0] sync_q;
  logic [PRE_W-1:0]       pre_cnt;
  logic                   rise_evt, fall_evt, base_evt, pre_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};

  assign rise_evt = sync_q[SYNC_STAGES-2] & ~sync_q[SYNC_STAGES-1];
  assign fall_evt = ~sync_q[SYNC_STAGES-2] & sync_q[SYNC_STAGES-1];
  assign base_evt = src_ext ? (ext_fall ? fall_evt : rise_evt) : 1'b1;
  assign pre_done = (pre_cnt == pre_limit(pre_n));
  assign tick     = run & base_evt & (~pre_en | pre_done);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       pre_cnt <= '0;
    else if (clear_pre)               pre_cnt <= '0;
    else if (run & base_evt & pre_en) pre_cnt <= pre_done ? '0 : pre_cnt + PRE_W'(1);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reload,
  input  logic         down,
  input  logic         ivl,
  input  logic [W-1:0] interval,
  output logic [W-1:0] cnt,
  output logic [W-1:0] next_cnt,
  output logic         wrap
);
  function automatic logic [W-1:0] start_value(input logic d, input logic i,
                                               input logic [W-1:0] lim);
    if (!d)     return '0;
    else if (i) return lim;
    else        return '1;
  endfunction

  logic at_end;

  assign at_end   = down ? (cnt == '0) : (ivl ? (cnt == interval) : (cnt == '1));
  assign wrap     = tick & at_end;
  assign next_cnt = down ? (at_end ? (ivl ? interval : '1) : cnt - W'(1))
                         : (at_end ? '0 : cnt + W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= '0;
    else if (reload) cnt <= start_value(down, ivl, interval);
    else if (tick)   cnt <= next_cnt;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRE_N_W   = 4,
  parameter int NUM_MATCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic              wave_out
);
  localparam int NUM_IRQ  = NUM_MATCH + 1;
  localparam int WRAP_BIT = NUM_MATCH;
  localparam int WAVE_IDX = 1;

  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   ivl_q;
  logic [CNT_W-1:0]   match_q [NUM_MATCH];
  logic [NUM_IRQ-1:0] ien_q, stat_q, stat_set, stat_clr;
  logic [NUM_MATCH-1:0] match_hit;
  logic [CNT_W-1:0]   cnt, next_cnt;
  logic               tick, wrap, reload_stb, wave_q;

  assign reload_stb = wr_en && (addr == A_COUNT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      ivl_q  <= '0;
      ien_q  <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl_q <= ctrl_t'(wdata[CTRL_BITS-1:0]);
      if (addr == A_IVL)  ivl_q  <= wdata;
      if (addr == A_IEN)  ien_q  <= wdata[NUM_IRQ-1:0];
    end

  tmr_tick_gen #(.PRE_W(CNT_W), .PRE_N_W(PRE_N_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
    .src_ext(ctrl_q.src_ext), .ext_fall(ctrl_q.ext_fall),
    .pre_en(ctrl_q.pre_en), .pre_n(ctrl_q.pre_n),
    .run(~ctrl_q.halt), .clear_pre(reload_stb), .tick(tick));

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload_stb),
    .down(ctrl_q.count_down), .ivl(ctrl_q.interval_mode), .interval(ivl_q),
    .cnt(cnt), .next_cnt(next_cnt), .wrap(wrap));

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) match_q[i] <= '0;
      else if (wr_en && addr == ADDR_W'(int'(A_MATCH0) + i)) match_q[i] <= wdata;
    assign match_hit[i] = tick && !reload_stb && (next_cnt == match_q[i]);
    assign stat_set[i]  = match_hit[i] & ctrl_q.match_en;
  end

  assign stat_set[WRAP_BIT] = wrap & ~reload_stb;
  assign stat_clr = (wr_en && addr == A_STAT) ? wdata[NUM_IRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~stat_clr) | stat_set;

  assign irq = |(stat_q & ien_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          wave_q <= 1'b0;
    else if (reload_stb || wrap)         wave_q <= 1'b0;
    else if (match_hit[WAVE_IDX])        wave_q <= ~wave_q;

  assign wave_out = ctrl_q.wave_off ? ctrl_q.wave_pol : (wave_q ^ ctrl_q.wave_pol);

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = CNT_W'(ctrl_q);
      A_COUNT: rdata = cnt;
      A_IVL:   rdata = ivl_q;
      A_IEN:   rdata = CNT_W'(ien_q);
      A_STAT:  rdata = CNT_W'(stat_q);
      default: begin
        for (int i = 0; i < NUM_MATCH; i++)
          if (addr == ADDR_W'(int'(A_MATCH0) + i)) rdata = match_q[i];
      end
    endcase
  end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W   = 16,
  parameter int NUM_IRQ = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               halt,
  input logic               down,
  input logic               ivl,
  input logic               reload_stb,
  input logic               tick,
  input logic               wrap,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   interval,
  input logic [NUM_IRQ-1:0] stat_set,
  input logic [NUM_IRQ-1:0] stat_q,
  input logic               irq,
  input logic               wave_q
);
  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) halt |-> !tick); // R4
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (halt && !reload_stb) |=> (cnt == $past(cnt))); // R4
  AST_RELOAD_UP: assert property (@(posedge clk) disable iff (!rst_n) (reload_stb && !down) |=> (cnt == '0)); // R5
  AST_RELOAD_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (reload_stb && down) |=> (cnt == ($past(ivl) ? $past(interval) : {CNT_W{1'b1}}))); // R5
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n) (tick && !reload_stb && !down && !wrap) |=> (cnt == $past(cnt) + CNT_W'(1))); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (tick && !reload_stb && down && !wrap) |=> (cnt == $past(cnt) - CNT_W'(1))); // R13
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (|stat_set) |=> ((stat_q & $past(stat_set)) == $past(stat_set))); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (stat_q == '0) |-> !irq); // R9
  AST_WAVE_WRAP: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> !wave_q); // R12
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(ctrl_q.halt), .down(ctrl_q.count_down),
  .ivl(ctrl_q.interval_mode), .reload_stb(reload_stb), .tick(tick), .wrap(wrap),
  .cnt(cnt), .interval(ivl_q), .stat_set(stat_set), .stat_q(stat_q),
  .irq(irq), .wave_q(wave_q));

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  // control bit values (R2)
  localparam logic [15:0] B_HALT = 16'h0001, B_EXT = 16'h0002, B_FALL = 16'h0004,
                          B_IVL  = 16'h0008, B_DOWN = 16'h0010, B_MEN = 16'h0020,
                          B_WOFF = 16'h0040, B_WPOL = 16'h0080, B_PEN = 16'h0100;

  logic        clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        irq, wave_out;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] cfg = '0;

  tmr_channel u0 (.clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_en(wr_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
                  .wave_out(wave_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  // entered at a negedge, returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  // exactly n system clock edges with halt clear (n >= 1)
  task automatic run(input int n);
    wr(3'd0, cfg & ~B_HALT);
    repeat (n - 1) @(negedge clk);
    wr(3'd0, cfg | B_HALT);
  endtask

  task automatic setup(input logic [15:0] c);
    cfg = c | B_HALT;
    wr(3'd0, cfg);
    wr(3'd1, 16'h0);      // reload
    wr(3'd7, 16'hFFFF);   // clear status
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd0, v); check("R1 ctrl", v, 16'h0041);
    rd(3'd1, v); check("R1 count", v, 16'h0000);
    rd(3'd6, v); check("R1 ien", v, 16'h0000);
    rd(3'd7, v); check("R1 stat", v, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0);
    check("R1 wave", {15'd0, wave_out}, 16'h0);
  endtask

  task automatic t_up_hold();
    logic [15:0] v;
    setup(B_WOFF);
    run(5);
    rd(3'd1, v); check("R3 up count", v, 16'd5);
    repeat (10) @(negedge clk);
    rd(3'd1, v); check("R4 hold", v, 16'd5);
    run(2);
    rd(3'd1, v); check("R4 resume", v, 16'd7);
  endtask

  task automatic t_reload_running();
    logic [15:0] v;
    setup(B_WOFF);
    wr(3'd0, cfg & ~B_HALT);
    repeat (3) @(negedge clk);
    wr(3'd1, 16'h0);          // reload while running
    repeat (2) @(negedge clk);
    rd(3'd0, v); check("R5 halt unchanged", v & B_HALT, 16'h0);
    wr(3'd0, cfg | B_HALT);
    rd(3'd1, v); check("R5 still counting", v, 16'd3);
  endtask

  task automatic t_down();
    logic [15:0] v;
    setup(B_WOFF | B_DOWN);
    rd(3'd1, v); check("R5 down free reload", v, 16'hFFFF);
    run(1);
    rd(3'd1, v); check("R13 decrement", v, 16'hFFFE);
    wr(3'd2, 16'd3);
    setup(B_WOFF | B_DOWN | B_IVL);
    rd(3'd1, v); check("R5 down ivl reload", v, 16'd3);
    run(1);
    rd(3'd7, v); check("R6 no wrap yet", v, 16'h0);
    run(3);
    rd(3'd1, v); check("R6 down ivl wrap value", v, 16'd3);
    rd(3'd7, v); check("R6 down ivl status", v, 16'h8);
  endtask

  task automatic t_up_interval();
    logic [15:0] v;
    wr(3'd2, 16'd3);
    setup(B_WOFF | B_IVL);
    run(3);
    rd(3'd7, v); check("R6 up ivl before wrap", v, 16'h0);
    run(1);
    rd(3'd1, v); check("R6 up ivl wrap to 0", v, 16'd0);
    rd(3'd7, v); check("R6 up ivl status", v, 16'h8);
  endtask

  task automatic t_overflow();
    logic [15:0] v;
    wr(3'd2, 16'd2);
    setup(B_WOFF | B_DOWN | B_IVL);  // count = 2
    cfg = B_WOFF | B_DOWN | B_HALT;  // free-run, no reload
    wr(3'd0, cfg);
    run(3);
    rd(3'd1, v); check("R7 down overflow value", v, 16'hFFFF);
    rd(3'd7, v); check("R7 overflow status", v, 16'h8);
  endtask

  task automatic t_match_irq();
    logic [15:0] v;
    wr(3'd3, 16'd2); wr(3'd4, 16'd7); wr(3'd5, 16'd4);
    setup(B_WOFF | B_MEN);
    run(4);
    rd(3'd7, v); check("R8 match bits", v, 16'h5);
    wr(3'd7, 16'h1);
    rd(3'd7, v); check("R9 partial clear", v, 16'h4);
    wr(3'd6, 16'h0);
    check("R9 irq masked", {15'd0, irq}, 16'h0);
    wr(3'd6, 16'h4);
    check("R9 irq enabled", {15'd0, irq}, 16'h1);
    wr(3'd6, 16'h1);
    check("R9 irq other bit", {15'd0, irq}, 16'h0);
    wr(3'd6, 16'h0);
    setup(B_WOFF);
    run(4);
    rd(3'd7, v); check("R8 match disabled", v, 16'h0);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    setup(B_WOFF | B_PEN);              // N=0, ratio 2
    run(10);
    rd(3'd1, v); check("R10 ratio 2", v, 16'd5);
    setup(B_WOFF | B_PEN | 16'h0400);  // N=2, ratio 8
    run(40);
    rd(3'd1, v); check("R10 ratio 8", v, 16'd5);
  endtask

  task automatic t_ext();
    logic [15:0] v;
    ext_clk = 1'b0;
    setup(B_WOFF | B_EXT);
    repeat (6) @(negedge clk);
    wr(3'd0, cfg & ~B_HALT);
    for (int p = 0; p < 3; p++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
    wr(3'd0, cfg | B_HALT);
    rd(3'd1, v); check("R11 rising edges", v, 16'd3);
    setup(B_WOFF | B_EXT | B_FALL);
    wr(3'd0, cfg & ~B_HALT);
    ext_clk = 1'b1; repeat (6) @(negedge clk);
    rd(3'd1, v); check("R11 falling ignores rise", v, 16'd0);
    ext_clk = 1'b0; repeat (6) @(negedge clk);
    wr(3'd0, cfg | B_HALT);
    rd(3'd1, v); check("R11 falling edge", v, 16'd1);
  endtask

  task automatic t_wave();
    logic [15:0] v;
    wr(3'd2, 16'd5); wr(3'd4, 16'd2);
    setup(B_IVL);
    check("R12 idle after reload", {15'd0, wave_out}, 16'h0);
    run(2);
    check("R12 toggled on match 1", {15'd0, wave_out}, 16'h1);
    run(3);
    check("R12 held to limit", {15'd0, wave_out}, 16'h1);
    run(1);
    rd(3'd1, v); check("R12 count wrapped", v, 16'd0);
    check("R12 back on wrap", {15'd0, wave_out}, 16'h0);
    cfg = B_IVL | B_WPOL | B_HALT; wr(3'd0, cfg);
    check("R12 inverted idle", {15'd0, wave_out}, 16'h1);
    run(2);
    check("R12 inverted active", {15'd0, wave_out}, 16'h0);
    cfg = B_IVL | B_WOFF | B_HALT; wr(3'd0, cfg);
    check("R12 disabled", {15'd0, wave_out}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up_hold();
    t_reload_running();
    t_down();
    t_up_interval();
    t_overflow();
    t_match_irq();
    t_prescale();
    t_ext();
    t_wave();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule